// File: doc/BRIEF.md
# E1 CRC-4 Multiframe Generator and Checker

This block adds CRC-4 multiframe protection to a 2.048 Mbit/s E1 stream, one bit for each clock cycle on which the bit enable is high. An existing basic framer supplies, separately for each direction, the position of the current bit inside its frame and the frame number inside the 16-frame multiframe. On the transmit side the block passes the payload through. It substitutes the multiframe overhead in timeslot 0: the C-bits, the multiframe alignment pattern, the two E-bits and the remote alarm bit.

The multiframe is split into two halves of eight frames, called submultiframes. Each carries 2048 bits. Over every transmitted half the block divides the data, shifted up by four places, by x^4 + x + 1. The 4-bit remainder goes into the four C-bit slots of the following half. The receive side runs the same division over each incoming half. It collects the C-bits of the following half and compares the two. It reports a result for each half checked, and it returns the outcome to the far end through the transmitted E-bits. E-bits of 0 that arrive from the far end are reported as well.

Top module: `e1crc_mf`

## Requirements
- R1: Frame index 0..15 numbers the multiframe, and bit index 0 is the first bit of timeslot 0. Even frames hold FAS words and odd frames hold NFAS words. Half 1 is frames 0..7 and half 2 is frames 8..15. A transmit bit that is not bit index 0 of any frame, and not bit index 2 of an odd frame, appears on `tx_data_out` unchanged in the same cycle.
- R2: At bit index 0 of odd frames 1, 3, 5, 7, 9 and 11, the transmitted bits are 0, 0, 1, 0, 1, 1, in that order.
- R3: The transmit remainder covers every bit of one half as transmitted. C-bit slots count as 0 in that sum. The register restarts at 0 with the first bit of each half, and the remainder is taken after the last bit of the half.
- R4: At bit index 0 of the even frames of a half, the remainder of the previous half is sent most significant coefficient first. Frame offsets 0, 2, 4 and 6 inside the half carry the x^3, x^2, x^1 and x^0 coefficients. From reset until the first remainder is taken, the value sent is 0000.
- R5: At bit index 2 of every odd frame, the transmitted bit equals `tx_alarm`.
- R6: The receive side computes the remainder of each incoming half by the rule of R3. Enabled bit index 0 of frame 6 or frame 14 supplies the last received C-bit. One cycle after that bit, `rx_chk_done` pulses for one cycle. `rx_crc_err` is 1 when the received C-bits differ from the remainder. `rx_chk_smf` is 1 when half 2 of the previous multiframe was checked (frame 6) and 0 when half 1 was checked (frame 14).
- R7: No check is reported until one complete half has been received after reset.
- R8: The bits at transmit bit index 0 of frame 13 and frame 15 are E1 and E2. Both are 1 after reset. E1 becomes 0 after a failed half-1 check and 1 after a passed one. E2 follows the half-2 checks in the same way.
- R9: A received 0 at enabled bit index 0 of frame 13 or frame 15 makes `rx_far_err` pulse one cycle later. `rx_far_smf` is 0 for frame 13 and 1 for frame 15.
- R10: While a bit enable is low, that direction advances no state and no result pulses.
- R11: During and directly after reset, all registered outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_bit_en | input | 1 | Transmit bit strobe |
| tx_bit_idx | input | 8 | Transmit bit position in frame (0..255) |
| tx_frm_idx | input | 4 | Transmit frame number in multiframe |
| tx_data_in | input | 1 | Transmit payload bit |
| tx_alarm | input | 1 | Remote alarm value to send |
| tx_data_out | output | 1 | Transmit bit with overhead inserted |
| rx_bit_en | input | 1 | Receive bit strobe |
| rx_bit_idx | input | 8 | Receive bit position in frame |
| rx_frm_idx | input | 4 | Receive frame number in multiframe |
| rx_data_in | input | 1 | Received bit |
| rx_chk_done | output | 1 | Pulse: one half has been checked |
| rx_chk_smf | output | 1 | Half checked (0 = half 1, 1 = half 2) |
| rx_crc_err | output | 1 | Pulse: C-bit mismatch |
| rx_far_err | output | 1 | Pulse: far end reported an error |
| rx_far_smf | output | 1 | Half named by the far-end error |

## Verification
`tx_data_out` is combinational, so each transmit bit is due in the cycle it is driven. The bench drives it just after a falling edge and samples it one time unit later. The check pulses and far-end pulses come from registers loaded by the enabled C4 or E-bit. They are due at the falling edge that follows that rising edge, and on every other cycle they must be 0. The bench checks them there, including on idle cycles. A change to an E-bit shows at the next transmit bit that carries it. A remainder is first sent one half after its last bit, so the bench models these effects in the same step order as the design.

// File: rtl/e1crc_pkg.sv
package e1crc_pkg;

  localparam int CRC_W = 4;
  localparam int FRM_W = 4;
  localparam logic [CRC_W-1:0] CRC_TAPS = 4'b0011;

  // One serial division step: shift in d, subtract x^4 + x + 1 when the
  // outgoing degree-4 term is set (premultiplied form).
  function automatic logic [CRC_W-1:0] crc4_step(input logic [CRC_W-1:0] r,
                                                 input logic d);
    logic fb;
    fb = d ^ r[CRC_W-1];
    return {r[CRC_W-2:0], 1'b0} ^ (fb ? CRC_TAPS : '0);
  endfunction

  // Multiframe alignment bit sent in odd frame number 2k+1, k = 0..5.
  function automatic logic mfa_bit(input logic [2:0] k);
    logic b;
    case (k)
      3'd2, 3'd4, 3'd5: b = 1'b1;
      default:          b = 1'b0;
    endcase
    return b;
  endfunction

  // C-bit carried in slot s of a half: x^3 coefficient first.
  function automatic logic cbit_of(input logic [CRC_W-1:0] rem,
                                   input logic [1:0] slot);
    logic b;
    case (slot)
      2'd0:    b = rem[3];
      2'd1:    b = rem[2];
      2'd2:    b = rem[1];
      default: b = rem[0];
    endcase
    return b;
  endfunction

endpackage

// File: rtl/e1crc_pos_dec.sv
module e1crc_pos_dec
  import e1crc_pkg::*;
#(
  parameter int FRAME_BITS = 256,
  localparam int BIT_W = $clog2(FRAME_BITS)
) (
  input  logic [BIT_W-1:0] bit_idx,
  input  logic [FRM_W-1:0] frm_idx,
  output logic             cpos,
  output logic             nfas1,
  output logic             smf_first,
  output logic             smf_last,
  output logic [1:0]       cslot
);

  logic first_bit;

  assign first_bit = (bit_idx == '0);
  assign cpos      = first_bit & ~frm_idx[0];
  assign nfas1     = first_bit & frm_idx[0];
  assign smf_first = first_bit & (frm_idx[2:0] == 3'd0);
  assign smf_last  = (bit_idx == BIT_W'(FRAME_BITS - 1)) & (frm_idx[2:0] == 3'd7);
  assign cslot     = frm_idx[2:1];

endmodule

// File: rtl/e1crc_crc_accum.sv
module e1crc_crc_accum
  import e1crc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             smf_first,
  input  logic             smf_last,
  input  logic             cpos,
  input  logic             din,
  output logic [CRC_W-1:0] rem_q,
  output logic             rem_valid,
  output logic             rem_load
);

  logic [CRC_W-1:0] crc_q;
  logic [CRC_W-1:0] crc_base;
  logic [CRC_W-1:0] crc_nxt;
  logic             run_q;

  assign crc_base = smf_first ? '0 : crc_q;
  assign crc_nxt  = crc4_step(crc_base, din & ~cpos);
  assign rem_load = en & smf_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      crc_q     <= '0;
      rem_q     <= '0;
      rem_valid <= 1'b0;
      run_q     <= 1'b0;
    end else if (en) begin
      crc_q <= crc_nxt;
      if (smf_first) run_q <= 1'b1;
      if (smf_last) begin
        rem_q     <= crc_nxt;
        rem_valid <= run_q;
      end
    end
  end

endmodule

// File: rtl/e1crc_tx_ins.sv
module e1crc_tx_ins
  import e1crc_pkg::*;
#(
  parameter int FRAME_BITS = 256,
  localparam int BIT_W = $clog2(FRAME_BITS)
) (
  input  logic [BIT_W-1:0] bit_idx,
  input  logic [FRM_W-1:0] frm_idx,
  input  logic             cpos,
  input  logic             nfas1,
  input  logic [1:0]       cslot,
  input  logic [CRC_W-1:0] rem,
  input  logic             e1,
  input  logic             e2,
  input  logic             alarm,
  input  logic             din,
  output logic             dout
);

  logic alarm_pos;

  assign alarm_pos = (bit_idx == BIT_W'(2)) & frm_idx[0];

  always_comb begin
    dout = din;
    if (cpos) begin
      dout = cbit_of(rem, cslot);
    end else if (nfas1) begin
      case (frm_idx[3:1])
        3'd6:    dout = e1;
        3'd7:    dout = e2;
        default: dout = mfa_bit(frm_idx[3:1]);
      endcase
    end else if (alarm_pos) begin
      dout = alarm;
    end
  end

endmodule

// File: rtl/e1crc_rx_chk.sv
module e1crc_rx_chk
  import e1crc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             cpos,
  input  logic             nfas1,
  input  logic [1:0]       cslot,
  input  logic [FRM_W-1:0] frm_idx,
  input  logic             din,
  input  logic [CRC_W-1:0] ref_rem,
  input  logic             ref_valid,
  output logic             chk_done,
  output logic             chk_smf,
  output logic             crc_err,
  output logic             far_err,
  output logic             far_smf,
  output logic             e1,
  output logic             e2
);

  logic [2:0]       cw_q;
  logic [CRC_W-1:0] word;
  logic             last_c;
  logic             mismatch;
  logic             ebit_pos;

  assign word     = {cw_q, din};
  assign last_c   = en & cpos & (cslot == 2'd3);
  assign mismatch = (word != ref_rem);
  assign ebit_pos = nfas1 & (frm_idx[3:2] == 2'b11);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cw_q     <= '0;
      chk_done <= 1'b0;
      chk_smf  <= 1'b0;
      crc_err  <= 1'b0;
      far_err  <= 1'b0;
      far_smf  <= 1'b0;
      e1       <= 1'b1;
      e2       <= 1'b1;
    end else begin
      chk_done <= 1'b0;
      chk_smf  <= 1'b0;
      crc_err  <= 1'b0;
      far_err  <= 1'b0;
      far_smf  <= 1'b0;
      if (en && cpos) begin
        case (cslot)
          2'd0:    cw_q[2] <= din;
          2'd1:    cw_q[1] <= din;
          2'd2:    cw_q[0] <= din;
          default: cw_q    <= cw_q;
        endcase
      end
      if (last_c && ref_valid) begin
        chk_done <= 1'b1;
        chk_smf  <= ~frm_idx[3];
        crc_err  <= mismatch;
        if (frm_idx[3]) e1 <= ~mismatch;
        else            e2 <= ~mismatch;
      end
      if (en && ebit_pos) begin
        far_err <= ~din;
        far_smf <= frm_idx[1] & ~din;
      end
    end
  end

endmodule

// File: rtl/e1crc_mf.sv
module e1crc_mf
  import e1crc_pkg::*;
#(
  parameter int FRAME_BITS = 256,
  localparam int BIT_W = $clog2(FRAME_BITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_bit_en,
  input  logic [BIT_W-1:0] tx_bit_idx,
  input  logic [FRM_W-1:0] tx_frm_idx,
  input  logic             tx_data_in,
  input  logic             tx_alarm,
  output logic             tx_data_out,
  input  logic             rx_bit_en,
  input  logic [BIT_W-1:0] rx_bit_idx,
  input  logic [FRM_W-1:0] rx_frm_idx,
  input  logic             rx_data_in,
  output logic             rx_chk_done,
  output logic             rx_chk_smf,
  output logic             rx_crc_err,
  output logic             rx_far_err,
  output logic             rx_far_smf
);

  localparam int DIR_TX = 0;
  localparam int DIR_RX = 1;
  localparam int N_DIR  = 2;

  logic [N_DIR-1:0]            en_v, din_v, cpos_v, nfas_v, first_v, last_v;
  logic [N_DIR-1:0]            load_v, valid_v;
  logic [N_DIR-1:0][BIT_W-1:0] idx_v;
  logic [N_DIR-1:0][FRM_W-1:0] frm_v;
  logic [N_DIR-1:0][1:0]       slot_v;
  logic [N_DIR-1:0][CRC_W-1:0] rem_v;

  // Named internal events for the checker
  logic [CRC_W-1:0] tx_rem, rx_rem;
  logic             tx_rem_load, rx_rem_load, tx_rem_valid, rx_rem_valid;
  logic             e1_q, e2_q;

  assign en_v[DIR_TX]  = tx_bit_en;
  assign en_v[DIR_RX]  = rx_bit_en;
  assign idx_v[DIR_TX] = tx_bit_idx;
  assign idx_v[DIR_RX] = rx_bit_idx;
  assign frm_v[DIR_TX] = tx_frm_idx;
  assign frm_v[DIR_RX] = rx_frm_idx;
  assign din_v[DIR_TX] = tx_data_out;
  assign din_v[DIR_RX] = rx_data_in;

  generate
    for (genvar g = 0; g < N_DIR; g++) begin : g_dir
      e1crc_pos_dec #(.FRAME_BITS(FRAME_BITS)) u_pos (
        .bit_idx   (idx_v[g]),
        .frm_idx   (frm_v[g]),
        .cpos      (cpos_v[g]),
        .nfas1     (nfas_v[g]),
        .smf_first (first_v[g]),
        .smf_last  (last_v[g]),
        .cslot     (slot_v[g])
      );
      e1crc_crc_accum u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en_v[g]),
        .smf_first (first_v[g]),
        .smf_last  (last_v[g]),
        .cpos      (cpos_v[g]),
        .din       (din_v[g]),
        .rem_q     (rem_v[g]),
        .rem_valid (valid_v[g]),
        .rem_load  (load_v[g])
      );
    end
  endgenerate

  assign tx_rem       = rem_v[DIR_TX];
  assign rx_rem       = rem_v[DIR_RX];
  assign tx_rem_load  = load_v[DIR_TX];
  assign rx_rem_load  = load_v[DIR_RX];
  assign tx_rem_valid = valid_v[DIR_TX];
  assign rx_rem_valid = valid_v[DIR_RX];

  e1crc_tx_ins #(.FRAME_BITS(FRAME_BITS)) u_tx_ins (
    .bit_idx (tx_bit_idx),
    .frm_idx (tx_frm_idx),
    .cpos    (cpos_v[DIR_TX]),
    .nfas1   (nfas_v[DIR_TX]),
    .cslot   (slot_v[DIR_TX]),
    .rem     (tx_rem),
    .e1      (e1_q),
    .e2      (e2_q),
    .alarm   (tx_alarm),
    .din     (tx_data_in),
    .dout    (tx_data_out)
  );

  e1crc_rx_chk u_rx_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (rx_bit_en),
    .cpos      (cpos_v[DIR_RX]),
    .nfas1     (nfas_v[DIR_RX]),
    .cslot     (slot_v[DIR_RX]),
    .frm_idx   (rx_frm_idx),
    .din       (rx_data_in),
    .ref_rem   (rx_rem),
    .ref_valid (rx_rem_valid),
    .chk_done  (rx_chk_done),
    .chk_smf   (rx_chk_smf),
    .crc_err   (rx_crc_err),
    .far_err   (rx_far_err),
    .far_smf   (rx_far_smf),
    .e1        (e1_q),
    .e2        (e2_q)
  );

endmodule

// File: rtl/e1crc_mf_chk.sv
module e1crc_mf_chk #(
  parameter int FRAME_BITS = 256,
  localparam int BIT_W = $clog2(FRAME_BITS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tx_bit_idx_is0,
  input logic [BIT_W-1:0] tx_bit_idx,
  input logic [3:0]       tx_frm_idx,
  input logic             tx_data_in,
  input logic             tx_data_out,
  input logic             rx_bit_en,
  input logic [BIT_W-1:0] rx_bit_idx,
  input logic [3:0]       rx_frm_idx,
  input logic             rx_data_in,
  input logic             rx_chk_done,
  input logic             rx_crc_err,
  input logic             rx_far_err,
  input logic [3:0]       tx_rem,
  input logic [3:0]       rx_rem,
  input logic             tx_rem_load,
  input logic             rx_rem_load,
  input logic             tx_rem_valid,
  input logic             rx_rem_valid
);

  // R1: payload positions pass straight through
  a_r1_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_bit_idx_is0 && !(tx_bit_idx == BIT_W'(2) && tx_frm_idx[0]))
      |-> (tx_data_out == tx_data_in));

  // R3: transmit remainder only changes when a half ends
  a_r3_tx_rem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_rem_load |=> $stable(tx_rem));

  // R6: receive remainder held for the whole following half
  a_r6_rx_rem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_rem_load |=> $stable(rx_rem));

  // R4: zero C-bits until the first remainder exists
  a_r4_zero_until_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_rem_valid |-> (tx_rem == 4'd0));

  // R6: a check follows an enabled C4 slot
  a_r6_done_after_c4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_chk_done |-> ($past(rx_bit_en) && $past(rx_bit_idx) == '0
                     && $past(rx_frm_idx[2:0]) == 3'd6));

  // R6: an error is only flagged together with a check
  a_r6_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    rx_crc_err |-> rx_chk_done);

  // R7: no check without a completed receive half
  a_r7_needs_rem: assert property (@(posedge clk) disable iff (!rst_n)
    rx_chk_done |-> $past(rx_rem_valid));

  // R9: far-end error comes from a received zero E-bit
  a_r9_far_source: assert property (@(posedge clk) disable iff (!rst_n)
    rx_far_err |-> ($past(rx_bit_en) && !$past(rx_data_in)
                    && $past(rx_bit_idx) == '0
                    && $past(rx_frm_idx[3:2]) == 2'b11 && $past(rx_frm_idx[0])));

  // R10: result pulses last one cycle and stay quiet after idle
  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rx_chk_done |=> !rx_chk_done);
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_bit_en |=> (!rx_chk_done && !rx_far_err));

endmodule

bind e1crc_mf e1crc_mf_chk #(.FRAME_BITS(FRAME_BITS)) u_e1crc_mf_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .tx_bit_idx_is0 (tx_bit_idx == '0),
  .tx_bit_idx     (tx_bit_idx),
  .tx_frm_idx     (tx_frm_idx),
  .tx_data_in     (tx_data_in),
  .tx_data_out    (tx_data_out),
  .rx_bit_en      (rx_bit_en),
  .rx_bit_idx     (rx_bit_idx),
  .rx_frm_idx     (rx_frm_idx),
  .rx_data_in     (rx_data_in),
  .rx_chk_done    (rx_chk_done),
  .rx_crc_err     (rx_crc_err),
  .rx_far_err     (rx_far_err),
  .tx_rem         (tx_rem),
  .rx_rem         (rx_rem),
  .tx_rem_load    (tx_rem_load),
  .rx_rem_load    (rx_rem_load),
  .tx_rem_valid   (tx_rem_valid),
  .rx_rem_valid   (rx_rem_valid)
);

// File: tb/e1crc_mf_bench.sv
module e1crc_mf_bench;

  localparam int CLK_PERIOD = 10;
  localparam int FRAME_BITS = 256;
  localparam int SMF_BITS   = 8 * FRAME_BITS;
  localparam int MF_BITS    = 16 * FRAME_BITS;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_bit_en = 1'b0, tx_data_in = 1'b0, tx_alarm = 1'b0;
  logic [7:0] tx_bit_idx = '0, rx_bit_idx = '0;
  logic [3:0] tx_frm_idx = '0, rx_frm_idx = '0;
  logic       rx_bit_en = 1'b0, rx_data_in = 1'b0;
  logic       tx_data_out, rx_chk_done, rx_chk_smf, rx_crc_err, rx_far_err, rx_far_smf;

  int n_checks = 0;
  int n_fail   = 0;
  bit all_done = 1'b0;

  // bench model state
  logic [SMF_BITS-1:0] tx_buf, rx_buf;
  logic [3:0] tx_prev, rx_prev, rx_word;
  logic       rx_prev_ok, exp_e1, exp_e2;
  logic       exp_done, exp_smf, exp_err, exp_far, exp_fsmf;
  logic       corrupt_now;
  int         bad_slot;
  bit         mfa_ref [6] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1};

  always #(CLK_PERIOD/2) clk = ~clk;

  e1crc_mf #(.FRAME_BITS(FRAME_BITS)) u_e1crc_mf (
    .clk(clk), .rst_n(rst_n),
    .tx_bit_en(tx_bit_en), .tx_bit_idx(tx_bit_idx), .tx_frm_idx(tx_frm_idx),
    .tx_data_in(tx_data_in), .tx_alarm(tx_alarm), .tx_data_out(tx_data_out),
    .rx_bit_en(rx_bit_en), .rx_bit_idx(rx_bit_idx), .rx_frm_idx(rx_frm_idx),
    .rx_data_in(rx_data_in), .rx_chk_done(rx_chk_done), .rx_chk_smf(rx_chk_smf),
    .rx_crc_err(rx_crc_err), .rx_far_err(rx_far_err), .rx_far_smf(rx_far_smf)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  // Long division of the half, shifted up by four, by 1_0011.
  function automatic logic [3:0] ref_crc(input logic [SMF_BITS-1:0] b);
    logic [3:0] r;
    logic top, nb;
    r = '0;
    for (int i = 0; i < SMF_BITS + 4; i++) begin
      top = r[3];
      nb  = (i < SMF_BITS) ? b[i] : 1'b0;
      r   = {r[2:0], nb};
      if (top) r = r ^ 4'b0011;
    end
    return r;
  endfunction

  task automatic check_pulses(input string tag);
    check({"R6 done ", tag}, 32'(rx_chk_done), 32'(exp_done));
    check({"R6 err ", tag},  32'(rx_crc_err),  32'(exp_err));
    check({"R6 smf ", tag},  32'(rx_chk_smf),  32'(exp_smf));
    check({"R9 far ", tag},  32'(rx_far_err),  32'(exp_far));
    check({"R9 fsmf ", tag}, 32'(rx_far_smf),  32'(exp_fsmf));
    exp_done = 1'b0; exp_err = 1'b0; exp_smf = 1'b0; exp_far = 1'b0; exp_fsmf = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; tx_bit_en = 1'b0; rx_bit_en = 1'b0;
    repeat (3) @(negedge clk);
    check("R11 done", 32'(rx_chk_done), 0);
    check("R11 err",  32'(rx_crc_err),  0);
    check("R11 smf",  32'(rx_chk_smf),  0);
    check("R11 far",  32'(rx_far_err),  0);
    check("R11 fsmf", 32'(rx_far_smf),  0);
    rst_n = 1'b1;
    tx_prev = '0; rx_prev = '0; rx_prev_ok = 1'b0; rx_word = '0;
    exp_e1 = 1'b1; exp_e2 = 1'b1;
    exp_done = 1'b0; exp_err = 1'b0; exp_smf = 1'b0; exp_far = 1'b0; exp_fsmf = 1'b0;
    corrupt_now = 1'b0; bad_slot = 0;
    @(negedge clk);
    check_pulses("R11 after release");
  endtask

  function automatic logic data_bit(input int mode);
    if (mode == 1) return 1'b0;
    if (mode == 2) return 1'b1;
    return 1'($urandom_range(1));
  endfunction

  task automatic run(input int n_mf, input int mode, input int corrupt_pct, input int gap_pct);
    for (int pos = 0; pos < n_mf * MF_BITS; pos++) begin
      int    idx, frm, off, slot, k;
      bit    cp, nf;
      logic  din, alm, ex, rb;
      string tag;
      while (int'($urandom_range(99)) < gap_pct) begin
        @(negedge clk);
        check_pulses("R10");
        tx_bit_en = 1'b0; rx_bit_en = 1'b0;
        tx_data_in = 1'($urandom_range(1)); rx_data_in = 1'($urandom_range(1));
        tx_bit_idx = 8'($urandom_range(255)); rx_bit_idx = '0;
        rx_frm_idx = 4'd6;
      end
      @(negedge clk);
      check_pulses("R6/R9");
      idx  = pos % FRAME_BITS;
      frm  = (pos / FRAME_BITS) % 16;
      off  = (frm % 8) * FRAME_BITS + idx;
      cp   = (idx == 0) && (frm % 2 == 0);
      nf   = (idx == 0) && (frm % 2 == 1);
      slot = (frm % 8) / 2;
      k    = frm / 2;
      if (idx == 0 && frm % 8 == 0) begin
        corrupt_now = (int'($urandom_range(99)) < corrupt_pct);
        bad_slot    = int'($urandom_range(3));
      end
      din = data_bit(mode);
      alm = 1'($urandom_range(1));
      // transmit expectation
      if (cp) begin
        ex = tx_prev[3 - slot]; tag = "R3/R4 cbit";
      end else if (nf && k < 6) begin
        ex = mfa_ref[k]; tag = "R2 mfa";
      end else if (nf) begin
        ex = (k == 6) ? exp_e1 : exp_e2; tag = "R8 ebit";
      end else if (idx == 2 && frm % 2 == 1) begin
        ex = alm; tag = "R5 alarm";
      end else begin
        ex = din; tag = "R1 payload";
      end
      // receive stimulus
      if (cp) begin
        rb = rx_prev_ok ? rx_prev[3 - slot] : 1'($urandom_range(1));
        if (corrupt_now && slot == bad_slot) rb = ~rb;
        rx_word[3 - slot] = rb;
      end else if (nf && k >= 6) begin
        rb = ($urandom_range(3) != 0);
      end else if (nf) begin
        rb = mfa_ref[k];
      end else begin
        rb = data_bit(mode);
      end
      tx_bit_en = 1'b1; tx_bit_idx = 8'(idx); tx_frm_idx = 4'(frm);
      tx_data_in = din; tx_alarm = alm;
      rx_bit_en = 1'b1; rx_bit_idx = 8'(idx); rx_frm_idx = 4'(frm); rx_data_in = rb;
      #1;
      check(tag, 32'(tx_data_out), 32'(ex));
      tx_buf[off] = cp ? 1'b0 : ex;
      rx_buf[off] = cp ? 1'b0 : rb;
      if (cp && slot == 3 && rx_prev_ok) begin
        exp_done = 1'b1;
        exp_smf  = (frm < 8);
        exp_err  = (rx_word != rx_prev);
        if (frm >= 8) exp_e1 = ~exp_err;
        else          exp_e2 = ~exp_err;
      end
      if (nf && k >= 6) begin
        exp_far  = ~rb;
        exp_fsmf = (k == 7) && !rb;
      end
      if (idx == FRAME_BITS - 1 && frm % 8 == 7) begin
        tx_prev    = ref_crc(tx_buf);
        rx_prev    = ref_crc(rx_buf);
        rx_prev_ok = 1'b1;
      end
    end
    @(negedge clk);
    check_pulses("R6/R9 tail");
    tx_bit_en = 1'b0; rx_bit_en = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd20480));
    // random data, random corruption and gaps (R1..R10)
    do_reset();
    run(3, 0, 40, 20);
    // reset mid-stream: no check before a full half (R7), zeros, no errors
    do_reset();
    run(1, 1, 0, 0);
    // all ones, every half corrupted so E-bits drop (R8)
    run(1, 2, 100, 10);
    all_done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!all_done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired before completion");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

endmodule